// File: doc/BRIEF.md
# Chained-Operation Fixed-Point Functional Unit

This block is one cell of a reconfigurable execution array. In a single combinational pass it evaluates a dependent chain of one, two or three integer operations. Each stage takes the previous stage's result as its first operand. Its second operand is either an external word or an immediate. The chain is regular: every intermediate value goes only to the next stage, so no multiplexers sit between stages. A length field selects how many stages are active. The last active stage drives the primary result. The results of earlier active stages come out on an intermediate bus, so a neighbouring cell can use them.

Each stage is built for a fixed subset of three operation classes: bitwise logic, add/subtract/compare, and shift. A stage mask parameter sets that subset. Selecting an operation that the stage was not built for is reported as a configuration error. The move operation is accepted by every stage. It lets the cell forward a value unchanged toward a later row. Results are captured in an output register, so they appear one cycle after the request.

Top module: `chain_fu`

## Requirements
- R1: Logical opcodes give a bitwise result of stage input A and operand B: 1 = AND, 2 = OR, 3 = XOR, 4 = NOR.
- R2: Opcode 5 gives A+B and opcode 6 gives A-B, both wrapping modulo 2^32.
- R3: Opcode 7 gives 1 when A < B as signed values, and 0 otherwise. Opcode 8 does the same for unsigned values.
- R4: Opcode 9 shifts left, opcode 10 shifts right logically and opcode 11 shifts right arithmetically. Each shifts A by the low 5 bits of B.
- R5: Opcode 0 (move) passes A through unchanged. Every stage accepts it, whatever its class mask.
- R6: Stage 0 takes `in_a` as A, and stage k takes stage k-1's result as A. `out_res` is the result of the last active stage, where `cfg_len` (1 to 3) is the number of active stages.
- R7: When `cfg_imm_sel[k]` is 1, the B operand of stage k is immediate word k. When it is 0, B is external word k. Word k sits at bits k*32 of the packed buses.
- R8: With the default mask, stage 0 accepts logical and arithmetic opcodes, stage 1 accepts only shifts and stage 2 accepts all classes. An unsupported class in an active stage sets `out_err`. Inactive stages are never checked.
- R9: A `cfg_len` of 0 sets `out_err`.
- R10: Opcodes 12 to 15 are reserved. In an active stage they set `out_err`.
- R11: Outputs update one cycle after a clock edge with `in_valid` high, and `out_valid` follows `in_valid` with the same delay. While `in_valid` is low, `out_res`, `out_mid` and `out_err` hold their values.
- R12: Reset clears `out_valid`, `out_res`, `out_mid` and `out_err` to zero.
- R13: Slot k of `out_mid` carries stage k's result when stage k is active and not last, and zero otherwise. When `out_err` is set, `out_res` and `out_mid` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| cfg_len | input | 2 | Number of active stages |
| cfg_op | input | 12 | 4-bit opcode per stage, stage 0 in the low bits |
| cfg_imm_sel | input | 3 | Per-stage B source: 1 = immediate |
| in_a | input | 32 | First operand of stage 0 |
| in_b | input | 96 | External B word per stage |
| in_imm | input | 96 | Immediate B word per stage |
| out_valid | output | 1 | Result present |
| out_res | output | 32 | Result of the last active stage |
| out_mid | output | 64 | Intermediate results of stages 0 and 1 |
| out_err | output | 1 | Configuration error |

## Verification
The assertions take for granted that `in_valid` and the configuration inputs carry known values at every clock edge after reset. They also assume that the default class mask is in use: the class-error property checks stage 1 for a logical opcode only when the mask leaves that class out. The stimulus drives every input on the falling edge, so each value is stable at the rising edge. It keeps the default mask throughout. Random vectors cover all opcodes, including the reserved ones, and every length from 0 to 3. Idle cycles with changed inputs in between exercise the hold behaviour.

// File: rtl/chain_fu.sv
`timescale 1ns/1ps
module chain_fu #(
  parameter int WIDTH = 32,
  parameter int STAGES = 3,
  parameter logic [STAGES*3-1:0] STAGE_CLASSES = 9'b111_100_011
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic [$clog2(STAGES+1)-1:0] cfg_len,
  input  logic [STAGES*4-1:0]         cfg_op,
  input  logic [STAGES-1:0]           cfg_imm_sel,
  input  logic [WIDTH-1:0]            in_a,
  input  logic [STAGES*WIDTH-1:0]     in_b,
  input  logic [STAGES*WIDTH-1:0]     in_imm,
  output logic                        out_valid,
  output logic [WIDTH-1:0]            out_res,
  output logic [(STAGES-1)*WIDTH-1:0] out_mid,
  output logic                        out_err
);
  localparam int SHW = $clog2(WIDTH);
  localparam int LENW = $clog2(STAGES+1);

  localparam logic [3:0] OP_MOV = 4'd0, OP_AND = 4'd1, OP_OR = 4'd2, OP_XOR = 4'd3,
                         OP_NOR = 4'd4, OP_ADD = 4'd5, OP_SUB = 4'd6, OP_SLT = 4'd7,
                         OP_SLTU = 4'd8, OP_SLL = 4'd9, OP_SRL = 4'd10, OP_SRA = 4'd11;

  function automatic logic [2:0] op_class(input logic [3:0] op);
    if (op >= OP_AND && op <= OP_NOR) return 3'b001;
    if (op >= OP_ADD && op <= OP_SLTU) return 3'b010;
    if (op >= OP_SLL && op <= OP_SRA) return 3'b100;
    return 3'b000;
  endfunction

  function automatic logic [WIDTH-1:0] stage_fn(input logic [3:0] op,
                                               input logic [WIDTH-1:0] a,
                                               input logic [WIDTH-1:0] b);
    logic [SHW-1:0] sh;
    sh = b[SHW-1:0];
    case (op)
      OP_MOV:  return a;
      OP_AND:  return a & b;
      OP_OR:   return a | b;
      OP_XOR:  return a ^ b;
      OP_NOR:  return ~(a | b);
      OP_ADD:  return a + b;
      OP_SUB:  return a - b;
      OP_SLT:  return {{(WIDTH-1){1'b0}}, $signed(a) < $signed(b)};
      OP_SLTU: return {{(WIDTH-1){1'b0}}, a < b};
      OP_SLL:  return a << sh;
      OP_SRL:  return a >> sh;
      OP_SRA:  return WIDTH'($signed(a) >>> sh);
      default: return '0;
    endcase
  endfunction

  logic [WIDTH-1:0]        res_n;
  logic [STAGES*WIDTH-1:0] mid_n;
  logic                    err_n;

  always_comb begin
    logic [WIDTH-1:0] acc, opb, nxt;
    logic [3:0] op;
    acc = in_a;
    res_n = '0;
    mid_n = '0;
    err_n = (cfg_len == '0) || (int'(cfg_len) > STAGES);
    for (int k = 0; k < STAGES; k++) begin
      op  = cfg_op[k*4 +: 4];
      opb = cfg_imm_sel[k] ? in_imm[k*WIDTH +: WIDTH] : in_b[k*WIDTH +: WIDTH];
      nxt = stage_fn(op, acc, opb);
      if (k < int'(cfg_len)) begin
        if (op > OP_SRA || (op_class(op) & ~STAGE_CLASSES[k*3 +: 3]) != 3'b000)
          err_n = 1'b1;
        if (k == int'(cfg_len) - 1) res_n = nxt;
        else mid_n[k*WIDTH +: WIDTH] = nxt;
      end
      acc = nxt;
    end
    if (err_n) begin
      res_n = '0;
      mid_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_res   <= '0;
      out_mid   <= '0;
      out_err   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_res <= res_n;
        out_mid <= mid_n[(STAGES-1)*WIDTH-1:0];
        out_err <= err_n;
      end
    end
  end

  AST_ERR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> (out_res == '0 && out_mid == '0)); // R13
  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R11
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_res) && $stable(out_err))); // R11
  AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cfg_len == '0) |=> out_err); // R9
  AST_MOVE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cfg_len == LENW'(1) && cfg_op[3:0] == OP_MOV) |=> out_res == $past(in_a)); // R5
  AST_CLASS_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && int'(cfg_len) >= 2 && !STAGE_CLASSES[3] && cfg_op[7:4] == OP_AND) |=> out_err); // R8
endmodule

// File: tb/chain_fu_tb.sv
`timescale 1ns/1ps
module chain_fu_tb_top;
  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [1:0] cfg_len = 0;
  logic [11:0] cfg_op = 0;
  logic [2:0] cfg_imm_sel = 0;
  logic [31:0] in_a = 0;
  logic [95:0] in_b = 0, in_imm = 0;
  logic out_valid, out_err;
  logic [31:0] out_res;
  logic [63:0] out_mid;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  chain_fu dut_i (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cfg_len(cfg_len),
    .cfg_op(cfg_op), .cfg_imm_sel(cfg_imm_sel), .in_a(in_a), .in_b(in_b), .in_imm(in_imm),
    .out_valid(out_valid), .out_res(out_res), .out_mid(out_mid), .out_err(out_err));

  function automatic logic [31:0] model_op(int op, logic [31:0] a, logic [31:0] b);
    int unsigned s = b % 32;
    case (op)
      0: return a;
      1: return a & b;
      2: return a | b;
      3: return a ^ b;
      4: return ~(a | b);
      5: return a + b;
      6: return a - b;
      7: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      8: return (a < b) ? 32'd1 : 32'd0;
      9: return a << s;
      10: return a >> s;
      11: return 32'($signed(a) >>> s);
      default: return 32'd0;
    endcase
  endfunction

  function automatic bit model_ok(int stage, int op);
    int cls;
    if (op == 0) return 1;
    if (op > 11) return 0;
    cls = (op <= 4) ? 1 : (op <= 8) ? 2 : 3;
    if (stage == 0) return cls != 3;
    if (stage == 1) return cls == 3;
    return 1;
  endfunction

  task automatic check(string tag, bit ok, string what, logic [127:0] act, logic [127:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic run(string tag, int len, int o0, int o1, int o2, logic [2:0] isel,
                     logic [31:0] a, logic [95:0] b, logic [95:0] imm);
    int ops[3];
    logic [31:0] v, e_res;
    logic [63:0] e_mid;
    bit e_err;
    ops = '{o0, o1, o2};
    @(negedge clk);
    cfg_len = 2'(len); cfg_op = {4'(o2), 4'(o1), 4'(o0)}; cfg_imm_sel = isel;
    in_a = a; in_b = b; in_imm = imm; in_valid = 1;
    v = a; e_res = 0; e_mid = 0; e_err = (len == 0);
    for (int s = 0; s < len; s++) begin
      logic [31:0] bb;
      bb = isel[s] ? imm[s*32 +: 32] : b[s*32 +: 32];
      v = model_op(ops[s], v, bb);
      if (!model_ok(s, ops[s])) e_err = 1;
      if (s == len - 1) e_res = v;
      else e_mid[s*32 +: 32] = v;
    end
    if (e_err) begin e_res = 0; e_mid = 0; end
    @(posedge clk); #2;
    check(tag, out_valid === 1'b1 && out_res === e_res && out_mid === e_mid && out_err === e_err,
          "valid/res/mid/err", {out_valid, out_err, out_mid, out_res}, {1'b1, e_err, e_mid, e_res});
    @(negedge clk);
    in_valid = 0; in_a = ~in_a; cfg_op = ~cfg_op; cfg_len = ~cfg_len;
    @(posedge clk); #2;
    check("R11", out_valid === 1'b0 && out_res === e_res && out_mid === e_mid && out_err === e_err,
          "idle hold", {out_valid, out_err, out_mid, out_res}, {1'b0, e_err, e_mid, e_res});
  endtask

  initial begin
    #(200000 * 8);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    if (!done) $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R12", out_valid === 0 && out_res === 0 && out_mid === 0 && out_err === 0,
          "reset state", {out_valid, out_err, out_mid, out_res}, 0);
    @(negedge clk); rst_n = 1;
    run("R1", 1, 1, 0, 0, 3'b000, 32'hF0F0_1234, {64'h0, 32'hFF00_FF00}, 0);
    run("R1", 1, 2, 0, 0, 3'b000, 32'hF0F0_1234, {64'h0, 32'h0F00_000F}, 0);
    run("R1", 1, 3, 0, 0, 3'b000, 32'hAAAA_5555, {64'h0, 32'hFFFF_0000}, 0);
    run("R1", 1, 4, 0, 0, 3'b000, 32'h1234_0000, {64'h0, 32'h0000_00FF}, 0);
    run("R2", 1, 5, 0, 0, 3'b000, 32'hFFFF_FFFF, {64'h0, 32'h1}, 0);
    run("R2", 1, 6, 0, 0, 3'b000, 32'h0, {64'h0, 32'h1}, 0);
    run("R3", 1, 7, 0, 0, 3'b000, 32'hFFFF_FFFF, {64'h0, 32'h1}, 0);
    run("R3", 1, 8, 0, 0, 3'b000, 32'hFFFF_FFFF, {64'h0, 32'h1}, 0);
    run("R4", 2, 0, 9, 0, 3'b000, 32'h0000_0011, {32'h0, 32'd36, 32'h0}, 0);
    run("R4", 2, 0, 10, 0, 3'b000, 32'h8000_0000, {32'h0, 32'd4, 32'h0}, 0);
    run("R4", 3, 0, 0, 11, 3'b000, 32'h8000_0000, {32'd31, 64'h0}, 0);
    run("R5", 3, 0, 0, 0, 3'b111, 32'hDEAD_BEEF, {96{1'b1}}, {96{1'b1}});
    run("R6", 3, 5, 9, 3, 3'b000, 32'h10, {32'hFF, 32'd2, 32'h5}, 0);
    run("R7", 1, 5, 0, 0, 3'b001, 32'h100, {64'h0, 32'h1}, {64'h0, 32'h2000});
    run("R7", 2, 1, 10, 0, 3'b010, 32'hF0F0_F0F0, {32'h0, 32'd1, 32'hFFFF_0000}, {32'h0, 32'd8, 32'h0});
    run("R8", 2, 5, 1, 0, 3'b000, 32'h5, {96{1'b1}}, 0);
    run("R8", 1, 9, 0, 0, 3'b000, 32'h5, {96{1'b1}}, 0);
    run("R8", 1, 5, 1, 14, 3'b000, 32'h5, {64'h0, 32'h3}, 0);
    run("R9", 0, 5, 9, 5, 3'b000, 32'h5, {96{1'b1}}, 0);
    run("R10", 3, 0, 0, 12, 3'b000, 32'h5, 0, 0);
    run("R10", 1, 15, 0, 0, 3'b000, 32'h5, 0, 0);
    run("R13", 2, 6, 9, 0, 3'b000, 32'h1000, {32'h0, 32'd3, 32'h1}, 0);
    for (int i = 0; i < 400; i++)
      run("R6", $urandom_range(0, 3), $urandom_range(0, 15), $urandom_range(0, 15),
          $urandom_range(0, 15), 3'($urandom), $urandom,
          {$urandom, $urandom, $urandom}, {$urandom, $urandom, $urandom});
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule